// File: doc/BRIEF.md
# Streaming Max-Magnitude Index Finder

This block scans a vector of signed two's complement samples that arrive one per cycle and reports where the sample with the largest absolute value sits and how large that value is. A scan opens with a one-cycle start pulse that carries the vector length N. The samples then arrive over a valid/ready handshake. When the last sample has been accepted, a one-cycle done pulse presents the 1-based position of the winning sample and its magnitude.

The block handles each accepted sample in the cycle it arrives. It forms the magnitude, compares it with the running best, and makes a predicated capture, so it sustains one sample per cycle with no stall. The position is not kept as an up-counting index. A counter loaded with N-1 counts down once per accepted sample and is snapshotted whenever a new best appears. The reported position is N minus that snapshot. Because a new best needs a strictly larger magnitude, the earliest of several equal magnitudes wins.

Top module: `mmx_peak_finder`

## Requirements
- R1: While reset is asserted and after it is released, `smp_ready_o` and `done_o` are 0 and `idx_o` and `mag_o` are 0 until a scan completes.
- R2: A start accepted while idle with a nonzero length raises `smp_ready_o` from the next cycle. `smp_ready_o` stays high until the N-th sample is accepted and is 0 from the cycle after that acceptance.
- R3: A sample is accepted only on a cycle where both `smp_valid_i` and `smp_ready_o` are 1. Valid samples presented while idle have no effect on any output.
- R4: The magnitude of a sample is its absolute value, formed one bit wider than the sample. The most negative code -2^(DATA_W-1) yields +2^(DATA_W-1).
- R5: The running best is replaced only by a strictly larger magnitude, so among equal magnitudes the earliest position is reported. The best starts below every magnitude, so the first sample is always taken, even when it is zero.
- R6: `idx_o` is 1-based (first sample = 1, last = N), formed as N minus a count-down value captured on each new best.
- R7: `done_o` is high for exactly one cycle, the cycle after the clock edge that accepts the N-th sample. `idx_o` and `mag_o` take the result in that same cycle.
- R8: `idx_o` and `mag_o` hold their value after done until the next accepted start, which clears both to 0 from the following cycle.
- R9: A start pulse during a running scan is ignored. The scan keeps its original length.
- R10: A start with `len_i` equal to 0 is ignored, and the block stays idle.
- R11: With N = 1, the result is position 1 and the magnitude of the single sample.
- R12: With valid held high, N samples are accepted on N consecutive cycles, and done follows the last one with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle scan start request |
| len_i | input | LEN_W | Vector length N, sampled with start |
| smp_valid_i | input | 1 | Sample valid |
| smp_data_i | input | DATA_W | Signed two's complement sample |
| smp_ready_o | output | 1 | Block can accept a sample this cycle |
| done_o | output | 1 | One-cycle result strobe |
| idx_o | output | LEN_W | 1-based position of the largest magnitude |
| mag_o | output | DATA_W+1 | Largest magnitude, unsigned |

## Verification
`smp_ready_o` rises one cycle after an accepted start and falls one cycle after the N-th acceptance. `done_o`, `idx_o` and `mag_o` change one cycle after the edge that accepts the last sample, and the result clear also lands one cycle after an accepted start. The bench drives inputs on the falling edge. On every falling edge it compares all four outputs with a behavioural up-counting model, which advances on the rising edge from the same inputs, so each result is checked in exactly the cycle it is due. Directed scenarios also read the result at the falling edge right after the last accepted sample and compare it with hand-worked values for ties, the most negative code, N = 1, all-zero vectors, ignored starts and back-to-back streaming.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

endpackage

// File: rtl/mmx_abs.sv
module mmx_abs #(
    parameter int DATA_W = 16,
    localparam int MAG_W = DATA_W + 1
) (
    input  logic [DATA_W-1:0]       data_i,
    output logic signed [MAG_W-1:0] mag_o
);

    logic signed [MAG_W-1:0] ext;

    always_comb begin
        // widen first so that the most negative code does not wrap
        ext   = $signed({data_i[DATA_W-1], data_i});
        mag_o = ext[MAG_W-1] ? -ext : ext;
    end

endmodule

// File: rtl/mmx_scan_ctrl.sv
module mmx_scan_ctrl #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             valid_i,
    output logic             busy_o,
    output logic             load_o,
    output logic             accept_o,
    output logic             last_o,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] len_o
);

    import mmx_pkg::*;

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        load_o   = (st_q.ph == PH_IDLE) && start_i && (len_i != '0);
        accept_o = (st_q.ph == PH_SCAN) && valid_i;
        last_o   = accept_o && (st_q.cnt == '0);

        if (load_o) begin
            st_d.ph  = PH_SCAN;
            st_d.cnt = len_i - LEN_W'(1);
            st_d.len = len_i;
        end else if (accept_o) begin
            if (last_o) begin
                st_d.ph = PH_IDLE;
            end else begin
                st_d.cnt = st_q.cnt - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.ph == PH_SCAN);
    assign cnt_o  = st_q.cnt;
    assign len_o  = st_q.len;

endmodule

// File: rtl/mmx_peak_track.sv
module mmx_peak_track #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    localparam int MAG_W = DATA_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    accept_i,
    input  logic signed [MAG_W-1:0] mag_i,
    input  logic [LEN_W-1:0]        cnt_i,
    output logic signed [MAG_W-1:0] win_mag_o,
    output logic [LEN_W-1:0]        win_cnt_o
);

    typedef struct packed {
        logic signed [MAG_W-1:0] best;
        logic [LEN_W-1:0]        cap;
    } track_t;

    track_t st_d, st_q;
    logic   take;

    always_comb begin
        st_d = st_q;
        // predicated capture: strict compare keeps the earliest of equal values
        take      = accept_i && (mag_i > st_q.best);
        win_mag_o = take ? mag_i : st_q.best;
        win_cnt_o = take ? cnt_i : st_q.cap;

        if (load_i) begin
            st_d.best = '1;  // sentinel -1, below every magnitude
            st_d.cap  = '0;
        end else if (take) begin
            st_d.best = mag_i;
            st_d.cap  = cnt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{best: '1, cap: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mmx_peak_finder.sv
module mmx_peak_finder #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    localparam int MAG_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic              smp_ready_o,
    output logic              done_o,
    output logic [LEN_W-1:0]  idx_o,
    output logic [MAG_W-1:0]  mag_o
);

    typedef struct packed {
        logic             done;
        logic [LEN_W-1:0] idx;
        logic [MAG_W-1:0] mag;
    } res_t;

    logic                    busy, load, accept, last;
    logic [LEN_W-1:0]        cnt, len;
    logic signed [MAG_W-1:0] smp_mag, win_mag;
    logic [LEN_W-1:0]        win_cnt;
    res_t                    res_d, res_q;

    mmx_scan_ctrl #(
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .len_i    (len_i),
        .valid_i  (smp_valid_i),
        .busy_o   (busy),
        .load_o   (load),
        .accept_o (accept),
        .last_o   (last),
        .cnt_o    (cnt),
        .len_o    (len)
    );

    mmx_abs #(
        .DATA_W (DATA_W)
    ) u_abs (
        .data_i (smp_data_i),
        .mag_o  (smp_mag)
    );

    mmx_peak_track #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .accept_i  (accept),
        .mag_i     (smp_mag),
        .cnt_i     (cnt),
        .win_mag_o (win_mag),
        .win_cnt_o (win_cnt)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = last;
        if (load) begin
            res_d.idx = '0;
            res_d.mag = '0;
        end else if (last) begin
            // position = N minus the remaining count captured at the best sample
            res_d.idx = len - win_cnt;
            res_d.mag = $unsigned(win_mag);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign smp_ready_o = busy;
    assign done_o      = res_q.done;
    assign idx_o       = res_q.idx;
    assign mag_o       = res_q.mag;

endmodule

// File: rtl/mmx_peak_chk.sv
module mmx_peak_chk #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    localparam int MAG_W = DATA_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [LEN_W-1:0]  len_i,
    input logic              smp_valid_i,
    input logic              smp_ready_o,
    input logic              done_o,
    input logic [LEN_W-1:0]  idx_o,
    input logic [MAG_W-1:0]  mag_o
);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !smp_ready_o);

    // R6
    idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (idx_o != '0));

    // R4
    mag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mag_o <= MAG_W'(1) << (DATA_W - 1)));

    // R3
    no_accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready_o && !smp_valid_i) |=> smp_ready_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(start_i && !smp_ready_o && (len_i != '0)))
            |-> ($stable(idx_o) && $stable(mag_o)));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_ready_o && !done_o && start_i && (len_i == '0)) |=> !smp_ready_o);

endmodule

bind mmx_peak_finder mmx_peak_chk #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .done_o      (done_o),
    .idx_o       (idx_o),
    .mag_o       (mag_o)
);

// File: tb/sim_mmx_peak_finder.sv
module sim_mmx_peak_finder;

    localparam int DW = 8;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          smp_valid_i = 1'b0;
    logic [DW-1:0] smp_data_i = '0;
    logic          smp_ready_o, done_o;
    logic [LW-1:0] idx_o;
    logic [DW:0]   mag_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    mmx_peak_finder #(.DATA_W(DW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .smp_ready_o(smp_ready_o), .done_o(done_o), .idx_o(idx_o), .mag_o(mag_o)
    );

    // behavioural reference: up-counting position, integers only
    bit m_busy = 0;
    int m_len = 0, m_seen = 0, m_best = -1, m_bpos = 0;
    bit e_done = 0;
    int e_idx = 0, e_mag = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; e_done = 0; e_idx = 0; e_mag = 0;
        end else begin
            e_done = 0;
            if (!m_busy) begin
                if (start_i && len_i != 0) begin
                    m_busy = 1; m_len = len_i; m_seen = 0;
                    m_best = -1; m_bpos = 0; e_idx = 0; e_mag = 0;
                end
            end else if (smp_valid_i) begin
                int sv, a;
                sv = $signed(smp_data_i);
                a  = (sv < 0) ? -sv : sv;
                m_seen++;
                if (a > m_best) begin m_best = a; m_bpos = m_seen; end
                if (m_seen == m_len) begin
                    m_busy = 0; e_done = 1; e_idx = m_bpos; e_mag = m_best;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // compare with the model on every falling edge
    always @(negedge clk) begin
        chk(smp_ready_o == m_busy, "R2 ready", int'(smp_ready_o), int'(m_busy));
        chk(done_o == e_done, "R7 done", int'(done_o), int'(e_done));
        chk(int'(idx_o) == e_idx, "R6 index", int'(idx_o), e_idx);
        chk(int'(mag_o) == e_mag, "R4 magnitude", int'(mag_o), e_mag);
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(int v);
        bit got = 0;
        while (!got) begin
            smp_valid_i = 1'b1;
            smp_data_i  = v[DW-1:0];
            got = smp_ready_o;
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
    endtask

    task automatic kick(int n);
        start_i = 1'b1;
        len_i   = n[LW-1:0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic expect_done(string req, int idx, int mag);
        chk(done_o == 1'b1, req, int'(done_o), 1);
        chk(int'(idx_o) == idx, req, int'(idx_o), idx);
        chk(int'(mag_o) == mag, req, int'(mag_o), mag);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(smp_ready_o == 0 && done_o == 0, "R1 reset", int'(smp_ready_o), 0);
        chk(idx_o == 0 && mag_o == 0, "R1 reset result", int'(idx_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: valid while idle has no effect
        smp_valid_i = 1'b1; smp_data_i = 8'h55;
        repeat (3) @(negedge clk);
        smp_valid_i = 1'b0;
        chk(smp_ready_o == 0 && done_o == 0 && idx_o == 0, "R3 idle valid", int'(smp_ready_o), 0);

        // R10: zero length start ignored
        kick(0);
        chk(smp_ready_o == 0, "R10 zero length", int'(smp_ready_o), 0);

        // R5: tie keeps earliest; R6: 1-based
        kick(5);
        send(3); send(-7); send(2); send(7); send(-1);
        expect_done("R5 tie earliest", 2, 7);

        // R8: held after done, cleared by next start
        repeat (3) @(negedge clk);
        chk(int'(idx_o) == 2 && int'(mag_o) == 7, "R8 hold", int'(idx_o), 2);
        kick(4);
        chk(idx_o == 0 && mag_o == 0, "R8 clear on start", int'(idx_o), 0);

        // R4: most negative code
        send(100); send(-128); send(127); send(-128);
        expect_done("R4 most negative", 2, 128);

        // R11: single sample
        kick(1);
        send(-5);
        expect_done("R11 single", 1, 5);

        // R5: all zeros, first one captured
        kick(3);
        send(0); send(0); send(0);
        expect_done("R5 zeros", 1, 0);

        // R9: start during scan ignored
        kick(3);
        send(1);
        kick(7);
        send(-9); send(4);
        expect_done("R9 start ignored", 2, 9);

        // R3: bubbles between samples
        kick(6);
        send(5); repeat (2) @(negedge clk);
        send(-6); @(negedge clk);
        send(6); send(-20); repeat (3) @(negedge clk);
        send(19); send(-20);
        expect_done("R3 bubbles", 4, 20);

        // R12: back to back, one sample per cycle
        kick(8);
        t0 = cyc;
        for (int i = 0; i < 8; i++) send((i * 13) - 50);
        chk(cyc - t0 == 8, "R12 throughput", cyc - t0, 8);
        expect_done("R12 back to back", 1, 50);

        // last sample is the peak
        kick(4);
        send(1); send(2); send(3); send(-90);
        expect_done("R6 last position", 4, 90);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule